// File: doc/BRIEF.md
# Dual Down-Counting Timer

The block holds two independent 16-bit down-counters behind one small synchronous register port. Each counter has its own reload register, control register, interrupt-clear register and level interrupt line. Software writes a start value, chooses how fast the counter steps and whether it wraps or reloads, and then sets the enable bit. From then on the counter steps down once per counting tick. When a step leaves it at zero, it raises its interrupt. The interrupt stays raised until software writes to that counter's clear register.

Both counters take their ticks from one shared prescaler. Each counter picks its own rate: every clock, every 16th clock or every 256th clock. A counter in free-running mode steps from zero to all ones and keeps going. A counter in periodic mode takes its reload value again when it steps away from zero. Read data is registered, so a read returns its word one clock after the read strobe is sampled.

Top module: `dual_down_timer`

## Requirements
- R1: After reset every reload, value and control register reads as zero, both interrupt lines are low, and the read data output is zero.
- R2: Each timer occupies a 0x20-byte slot: timer 0 at 0x00 and timer 1 at 0x20. Within a slot, the reload register is at offset 0x00, the current value at 0x04 (a write there has no effect), control at 0x08 and interrupt clear at 0x0C. A read of any other offset returns zero. Read data is captured on the clock edge that samples reg_rd and is held until the next read.
- R3: In the control word, bit 7 enables counting and bit 6 selects periodic mode (1) or free-running mode (0). Bits 3:2 set the rate: 00 means every clock, 01 every 16th clock, 10 every 256th clock, and 11 also every 256th clock. All other bits read back as zero.
- R4: A write to the reload register loads the counter on the same clock edge. It wins over a counting tick on that edge, and that tick then does not raise the interrupt.
- R5: While enabled, the counter steps down by exactly one per counting tick. While disabled it holds its value.
- R6: In free-running mode, a tick taken at zero gives 0xFFFF.
- R7: In periodic mode, a tick taken at zero gives the reload value.
- R8: A tick that leaves the counter at zero sets that timer's interrupt. The interrupt stays high until a write of any value to the timer's clear register. A set and a clear on the same edge leave it set.
- R9: In the every-16th and every-256th rates, ticks arrive exactly 16 and 256 clocks apart. In periodic mode with reload value L, the interrupt therefore rises every (L+1)*16 or (L+1)*256 clocks.
- R10: Register accesses and counting in one timer leave the other timer's registers, counter and interrupt unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_wr | input | 1 | Write strobe, sampled on the rising edge |
| reg_rd | input | 1 | Read strobe, sampled on the rising edge |
| reg_addr | input | 6 | Byte address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| irq | output | 2 | Level interrupt, one bit per timer |

## Verification
A register write takes effect on the edge that samples it. A read word is valid one edge after the read strobe, so the monitor compares it at the falling edge that follows the sampling edge. Expected counter values are worked out by counting ticks: with the every-clock rate, a write to enable the counter, k idle cycles and then a write to disable it give exactly k+1 steps. The shared prescaler's phase after reset is not visible at the ports. For that reason the slower rates are checked as the interval between two interrupt rises, both observed at the falling edge after the setting tick. That interval does not depend on the phase.

// File: rtl/dtimer_pkg.sv
package dtimer_pkg;

  // Rate choice held in the control register
  typedef enum logic [1:0] {
    PS_DIV1    = 2'b00,
    PS_DIV16   = 2'b01,
    PS_DIV256  = 2'b10,
    PS_DIV256B = 2'b11
  } ps_sel_e;

  typedef struct packed {
    logic    en;
    logic    periodic;
    ps_sel_e ps;
  } tmr_ctrl_t;

  // Control word bit positions
  localparam int CTRL_EN_BIT   = 7;
  localparam int CTRL_MODE_BIT = 6;
  localparam int CTRL_PS_LSB   = 2;

  // Per-timer slot layout
  localparam int SLOT_LOG = 5;
  localparam logic [SLOT_LOG-1:0] OFF_LOAD  = 5'h00;
  localparam logic [SLOT_LOG-1:0] OFF_VALUE = 5'h04;
  localparam logic [SLOT_LOG-1:0] OFF_CTRL  = 5'h08;
  localparam logic [SLOT_LOG-1:0] OFF_CLEAR = 5'h0C;

endpackage

// File: rtl/dtimer_rst_sync.sv
module dtimer_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  // Assert at once, release after STAGES edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/dtimer_prescaler.sv
module dtimer_prescaler #(
  parameter int MID_LOG  = 4,
  parameter int SLOW_LOG = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_mid,
  output logic tick_slow
);

  logic [SLOW_LOG-1:0] div_q, div_d;

  always_comb div_d = div_q + SLOW_LOG'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  // One-cycle pulses at the all-ones points of the free count
  assign tick_mid  = &div_q[MID_LOG-1:0];
  assign tick_slow = &div_q;

endmodule

// File: rtl/dtimer_channel.sv
module dtimer_channel
  import dtimer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_mid,
  input  logic             tick_slow,
  input  logic             wr_load,
  input  logic             wr_ctrl,
  input  logic             wr_clr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] load_q,
  output logic [CNT_W-1:0] cnt_q,
  output tmr_ctrl_t        ctrl_q,
  output logic             irq_q
);

  logic [CNT_W-1:0] load_d, cnt_d, step_val;
  tmr_ctrl_t        ctrl_d;
  logic             irq_d;
  logic             tick_sel, tick, hit_zero;

  // Rate selection from the shared pulses
  always_comb begin
    case (ctrl_q.ps)
      PS_DIV1:  tick_sel = 1'b1;
      PS_DIV16: tick_sel = tick_mid;
      default:  tick_sel = tick_slow;
    endcase
  end

  assign tick = ctrl_q.en & tick_sel;

  // Value after one step: decrement, or wrap/reload from zero
  always_comb begin
    if (cnt_q == '0) step_val = ctrl_q.periodic ? load_q : '1;
    else             step_val = cnt_q - CNT_W'(1);
  end

  assign hit_zero = tick & ~wr_load & (step_val == '0);

  always_comb begin
    load_d = load_q;
    cnt_d  = cnt_q;
    ctrl_d = ctrl_q;
    irq_d  = irq_q;
    if (wr_load) begin
      load_d = wdata;
      cnt_d  = wdata;
    end else if (tick) begin
      cnt_d = step_val;
    end
    if (wr_ctrl) begin
      ctrl_d.en       = wdata[CTRL_EN_BIT];
      ctrl_d.periodic = wdata[CTRL_MODE_BIT];
      ctrl_d.ps       = ps_sel_e'(wdata[CTRL_PS_LSB +: 2]);
    end
    if (hit_zero)    irq_d = 1'b1;
    else if (wr_clr) irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= '0;
      cnt_q  <= '0;
      ctrl_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      load_q <= load_d;
      cnt_q  <= cnt_d;
      ctrl_q <= ctrl_d;
      irq_q  <= irq_d;
    end
  end

endmodule

// File: rtl/dual_down_timer.sv
module dual_down_timer
  import dtimer_pkg::*;
#(
  parameter int NUM_TMR = 2,
  parameter int CNT_W   = 16,
  parameter int MID_LOG = 4,
  parameter int SLOW_LOG = 8,
  parameter int IDX_W   = (NUM_TMR > 1) ? $clog2(NUM_TMR) : 1,
  parameter int ADDR_W  = SLOT_LOG + IDX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [CNT_W-1:0]   reg_wdata,
  output logic [CNT_W-1:0]   reg_rdata,
  output logic [NUM_TMR-1:0] irq
);

  logic                rst_sync_n;
  logic                tick_mid, tick_slow;
  logic [IDX_W-1:0]    slot_idx;
  logic [SLOT_LOG-1:0] slot_off;

  logic [NUM_TMR-1:0]            wr_load, wr_ctrl, wr_clr, irq_all;
  logic [NUM_TMR-1:0][CNT_W-1:0] load_all, cnt_all, ctrl_word;
  tmr_ctrl_t [NUM_TMR-1:0]       ctrl_all;
  logic [CNT_W-1:0]              rd_d, rdata_q;

  dtimer_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dtimer_prescaler #(.MID_LOG(MID_LOG), .SLOW_LOG(SLOW_LOG)) u_ps (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .tick_mid  (tick_mid),
    .tick_slow (tick_slow)
  );

  assign slot_idx = reg_addr[ADDR_W-1:SLOT_LOG];
  assign slot_off = reg_addr[SLOT_LOG-1:0];

  for (genvar gi = 0; gi < NUM_TMR; gi++) begin : g_tmr
    logic sel;
    assign sel         = (slot_idx == IDX_W'(gi));
    assign wr_load[gi] = reg_wr & sel & (slot_off == OFF_LOAD);
    assign wr_ctrl[gi] = reg_wr & sel & (slot_off == OFF_CTRL);
    assign wr_clr[gi]  = reg_wr & sel & (slot_off == OFF_CLEAR);

    dtimer_channel #(.CNT_W(CNT_W)) u_ch (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .tick_mid  (tick_mid),
      .tick_slow (tick_slow),
      .wr_load   (wr_load[gi]),
      .wr_ctrl   (wr_ctrl[gi]),
      .wr_clr    (wr_clr[gi]),
      .wdata     (reg_wdata),
      .load_q    (load_all[gi]),
      .cnt_q     (cnt_all[gi]),
      .ctrl_q    (ctrl_all[gi]),
      .irq_q     (irq_all[gi])
    );

    always_comb begin
      ctrl_word[gi]                      = '0;
      ctrl_word[gi][CTRL_EN_BIT]         = ctrl_all[gi].en;
      ctrl_word[gi][CTRL_MODE_BIT]       = ctrl_all[gi].periodic;
      ctrl_word[gi][CTRL_PS_LSB +: 2]    = ctrl_all[gi].ps;
    end

    assign irq[gi] = irq_all[gi];
  end

  // Read selection
  always_comb begin
    rd_d = '0;
    for (int i = 0; i < NUM_TMR; i++) begin
      if (slot_idx == IDX_W'(i)) begin
        case (slot_off)
          OFF_LOAD:  rd_d = load_all[i];
          OFF_VALUE: rd_d = cnt_all[i];
          OFF_CTRL:  rd_d = ctrl_word[i];
          default:   rd_d = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  rdata_q <= '0;
    else if (reg_rd)  rdata_q <= rd_d;
  end

  assign reg_rdata = rdata_q;

endmodule

// File: rtl/dtimer_chk.sv
module dtimer_chk #(
  parameter int NUM_TMR = 2,
  parameter int CNT_W   = 16
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          reg_rd,
  input logic [CNT_W-1:0]              reg_wdata,
  input logic [CNT_W-1:0]              reg_rdata,
  input logic [NUM_TMR-1:0]            irq,
  input logic [NUM_TMR-1:0]            wr_load,
  input logic [NUM_TMR-1:0]            wr_clr,
  input logic [NUM_TMR-1:0][CNT_W-1:0] cnt
);

  // R2
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(reg_rdata));

  for (genvar gi = 0; gi < NUM_TMR; gi++) begin : g_chk
    // R8
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq[gi]) |-> $past(wr_clr[gi]));

    // R8
    irq_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq[gi]) |-> (cnt[gi] == '0));

    // R4
    load_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_load[gi] |=> (cnt[gi] == $past(reg_wdata)));

    // R5
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_load[gi] |=> ((cnt[gi] == $past(cnt[gi])) ||
                        (cnt[gi] == $past(cnt[gi]) - CNT_W'(1)) ||
                        ($past(cnt[gi]) == '0)));
  end

endmodule

bind dual_down_timer dtimer_chk #(.NUM_TMR(NUM_TMR), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .reg_rd    (reg_rd),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .irq       (irq),
  .wr_load   (wr_load),
  .wr_clr    (wr_clr),
  .cnt       (cnt_all)
);

// File: tb/dual_down_timer_tb.sv
module dual_down_timer_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [1:0]  irq;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;
  bit rd_seen = 1'b0;

  typedef struct {
    logic [15:0] exp;
    string       req;
  } exp_t;
  exp_t sb_q[$];

  dual_down_timer u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq       (irq)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc     <= cyc + 1;
    rd_seen <= reg_rd;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Monitor: compare read data one edge after the strobe
  always @(negedge clk) begin
    if (rd_seen) begin
      if (sb_q.size() == 0) chk("R2 unexpected read", 32'd1, 32'd0);
      else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(e.req, {16'h0, reg_rdata}, {16'h0, e.exp});
      end
    end
  end

  // Driver tasks: called at a falling edge, return at the next one
  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [15:0] exp, input string req);
    exp_t e;
    e.exp = exp; e.req = req;
    sb_q.push_back(e);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic wait_irq(input int ch, input string req, output int t);
    int n = 0;
    while (irq[ch] !== 1'b1 && n < 2000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 2000) chk({req, " timeout"}, 32'd0, 32'd1);
    t = cyc;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    int t1, t2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    chk("R1 rdata", {16'h0, reg_rdata}, 32'h0);
    chk("R1 irq", {30'h0, irq}, 32'h0);
    rd(6'h00, 16'h0000, "R1 load0");
    rd(6'h04, 16'h0000, "R1 value0");
    rd(6'h08, 16'h0000, "R1 ctrl0");
    rd(6'h28, 16'h0000, "R1 ctrl1");

    // R4 load write loads the counter
    wr(6'h00, 16'h1234);
    rd(6'h04, 16'h1234, "R4 value after load");
    rd(6'h00, 16'h1234, "R4 load readback");

    // R2 value register ignores writes, unmapped offset reads zero
    wr(6'h04, 16'h5555);
    rd(6'h04, 16'h1234, "R2 value write ignored");
    rd(6'h10, 16'h0000, "R2 unmapped offset");
    rd(6'h24, 16'h0000, "R10 timer1 untouched");

    // R3 only implemented control bits read back
    wr(6'h08, 16'hFF3F);
    rd(6'h08, 16'h000C, "R3 ctrl readback");
    wr(6'h08, 16'h0000);

    // R5 count at every-clock rate: enable, 4 idle, disable = 5 steps
    wr(6'h00, 16'd20);
    wr(6'h08, 16'h0080);
    idle(4);
    wr(6'h08, 16'h0000);
    rd(6'h04, 16'd15, "R5 five steps");
    idle(3);
    rd(6'h04, 16'd15, "R5 disabled holds");
    chk("R8 no irq before zero", {31'h0, irq[0]}, 32'h0);

    // R6 free-running wrap, 6 steps from 3
    wr(6'h00, 16'd3);
    wr(6'h08, 16'h0080);
    idle(5);
    wr(6'h08, 16'h0000);
    rd(6'h04, 16'hFFFD, "R6 wrap to FFFD");
    chk("R8 irq set at zero", {31'h0, irq[0]}, 32'h1);
    idle(5);
    chk("R8 irq held", {31'h0, irq[0]}, 32'h1);
    wr(6'h0C, 16'hABCD);
    chk("R8 irq cleared", {31'h0, irq[0]}, 32'h0);

    // R7 periodic reload, 6 steps from 3: 2,1,0,3,2,1
    wr(6'h00, 16'd3);
    wr(6'h08, 16'h00C0);
    idle(5);
    wr(6'h08, 16'h0000);
    rd(6'h04, 16'd1, "R7 periodic reload");
    chk("R7 irq on zero", {31'h0, irq[0]}, 32'h1);
    wr(6'h0C, 16'h0000);

    // R4 load wins over a tick while running
    wr(6'h00, 16'd100);
    wr(6'h08, 16'h0080);
    idle(2);
    wr(6'h00, 16'd50);
    wr(6'h08, 16'h0000);
    rd(6'h04, 16'd49, "R4 load priority");

    // R9 every-16th rate, periodic reload 1: period 32
    wr(6'h00, 16'd1);
    wr(6'h08, 16'h00C4);
    wait_irq(0, "R9 div16 first", t1);
    wr(6'h0C, 16'h0001);
    wait_irq(0, "R9 div16 second", t2);
    chk("R9 div16 period", t2 - t1, 32'd32);
    wr(6'h08, 16'h0000);
    wr(6'h0C, 16'h0000);

    // R9 every-256th rate, reload 0: period 256
    wr(6'h00, 16'd0);
    wr(6'h08, 16'h00C8);
    wait_irq(0, "R9 div256 first", t1);
    wr(6'h0C, 16'h0001);
    wait_irq(0, "R9 div256 second", t2);
    chk("R9 div256 period", t2 - t1, 32'd256);

    // R3 rate code 11 behaves as every 256th
    wr(6'h08, 16'h00CC);
    wr(6'h0C, 16'h0001);
    wait_irq(0, "R3 code11 first", t1);
    wr(6'h0C, 16'h0001);
    wait_irq(0, "R3 code11 second", t2);
    chk("R3 code11 period", t2 - t1, 32'd256);
    wr(6'h08, 16'h0000);
    wr(6'h0C, 16'h0000);

    // R10 timer1 runs alone: 6 periodic steps from 5 reach 0 then 5
    wr(6'h20, 16'd5);
    wr(6'h28, 16'h00C0);
    idle(5);
    wr(6'h28, 16'h0000);
    rd(6'h24, 16'd5, "R10 timer1 value");
    chk("R10 timer1 irq", {31'h0, irq[1]}, 32'h1);
    chk("R10 timer0 irq quiet", {31'h0, irq[0]}, 32'h0);
    rd(6'h00, 16'd0, "R10 timer0 load kept");
    rd(6'h08, 16'h0000, "R10 timer0 ctrl kept");
    wr(6'h2C, 16'h0000);
    chk("R10 timer1 irq cleared", {31'h0, irq[1]}, 32'h0);

    idle(2);
    chk("R2 scoreboard drained", sb_q.size(), 32'd0);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule